// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Filter Sleep Mode

This block is the receive half of an asynchronous serial port. A 16x oversampling tick paces it. It finds a start bit and checks it at mid-bit, then collects 7, 8 or 9 data bits least significant bit first. It can also collect a parity bit, followed by one or two stop bits. The finished word moves into a buffer register that software reads through a small synchronous register port. A one-cycle interrupt pulse announces each newly filled buffer. Status flags report a full buffer, overrun, framing error, parity error and their combined summary.

An active-low ready output can be enabled so that a sender is held off while a frame is in flight. A sleep bit makes the receiver drop every word whose most significant data bit is clear. On a shared line where address bytes carry that bit set, each station then sees only address bytes until software decides it has been selected and clears the sleep bit.

Top module: `uart_rx_sleep`

## Requirements
- R1: Register port. Address 0 is the read/write control register: bit0 enable, bit1 ready-output select, bit2 sleep, bits[4:3] length (0 gives 7 bits, 1 gives 8, 2 or 3 give 9), bit5 parity enable, bit6 odd parity (0 means even), bit7 two stop bits. Address 1 reads status: bit0 full, bit1 overrun, bit2 framing, bit3 parity, bit4 summary, upper bits 0. Address 2 reads buffer bits 7:0. Address 3 reads buffer bit 8 in bit0, upper bits 0. All of these read 0 after reset.
- R2: `rtsN` is 1 whenever the enable or the select bit is 0. With both set it is 0 while the receiver is idle, goes 1 once a start edge is seen, and returns to 0 after the word has been handed to the buffer.
- R3: A falling edge counts as a start bit only if the line is still low 8 ticks later (mid-bit). Otherwise the receiver returns to idle and leaves buffer and flags untouched.
- R4: Data bits are sampled at mid-bit, 16 ticks apart, and stored least significant bit first. At the end of the last stop bit the word is placed in the buffer, zero-extended to 9 bits, and the full flag is set.
- R5: `rxIrq` pulses for exactly one clock when the full flag goes from 0 to 1, and at no other time.
- R6: A transfer while the full flag is already 1 sets the overrun flag. The buffer takes the new word.
- R7: A stop bit sampled low sets the framing flag. The word is still delivered, and no new start bit is looked for until the line has returned high.
- R8: With parity enabled, a parity bit that does not give the selected parity (even or odd) over the data bits sets the parity flag. With parity disabled the flag is never set.
- R9: The summary flag equals the OR of the overrun, framing and parity flags.
- R10: Reading address 2 or clearing the enable bit clears all five flags. Reading address 3 or address 1 clears nothing.
- R11: With sleep set, a word whose top data bit (bit 6, 7 or 8 for 7, 8 or 9 bits) is 0 is discarded, and buffer, flags and `rxIrq` stay unchanged. A word with that bit set is received normally.
- R12: Length, parity and stop-bit settings are captured at the start edge. A write to the control register during a frame takes effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial receive line, idle high |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (side effects on address 2) |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| rtsN | output | 1 | Active-low ready-to-receive |
| rxIrq | output | 1 | Receive interrupt request pulse |

## Verification
The bench targets overrun, where a design that skipped the check would report clean data after a lost word. It also targets repeated interrupts on back-to-back unread words, which a level-triggered or transfer-triggered request would produce. A start glitch shorter than half a bit must leave no trace; a receiver that skipped mid-bit validation would assemble a shifted garbage word. Sleep frames with a clear top bit must leave the flags, the buffer and the interrupt untouched. A control write in mid-frame must not change the frame being received. A framing error with the line held low afterward must not be mistaken for a new start.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_XFER, RX_WAITHIGH
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic sampleData;
    logic sampleParity;
    logic sampleStop;
    logic finishFrame;
  } rxStrobes_t;

  localparam int WORD_MAX = 9;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic       rxEnable,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic       cfgTwoStop,
  output rxStrobes_t strobes,
  output logic       busy
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);

  rxState_t        state;
  logic [CNT_W-1:0] tickCnt;
  logic [3:0]      bitCnt;
  logic [1:0]      lenQ;
  logic            parQ, twoQ;
  logic            atSample;
  logic [3:0]      lastBit;

  assign atSample = tick16 && (tickCnt == LAST_CNT);
  assign lastBit  = (lenQ == 2'd0) ? 4'd6 : (lenQ == 2'd1) ? 4'd7 : 4'd8;
  assign busy     = (state != RX_IDLE);

  always_comb begin
    strobes = '0;
    strobes.startFrame   = (state == RX_IDLE) && rxEnable && tick16 && !rxLine;
    strobes.sampleData   = (state == RX_DATA) && atSample;
    strobes.sampleParity = (state == RX_PARITY) && atSample;
    strobes.sampleStop   = (state == RX_STOP) && atSample;
    strobes.finishFrame  = (state == RX_XFER);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      lenQ    <= '0;
      parQ    <= 1'b0;
      twoQ    <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: if (strobes.startFrame) begin
          state   <= RX_START;
          tickCnt <= '0;
          lenQ    <= cfgLen;
          parQ    <= cfgParEn;
          twoQ    <= cfgTwoStop;
        end
        RX_START: if (tick16) begin
          if (tickCnt == MID_CNT) begin
            state   <= rxLine ? RX_IDLE : RX_DATA;
            tickCnt <= '0;
            bitCnt  <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        RX_DATA: if (tick16) begin
          if (atSample) begin
            tickCnt <= '0;
            if (bitCnt == lastBit) begin
              bitCnt <= '0;
              state  <= parQ ? RX_PARITY : RX_STOP;
            end else bitCnt <= bitCnt + 1'b1;
          end else tickCnt <= tickCnt + 1'b1;
        end
        RX_PARITY: if (tick16) begin
          if (atSample) begin
            tickCnt <= '0;
            state   <= RX_STOP;
          end else tickCnt <= tickCnt + 1'b1;
        end
        RX_STOP: if (tick16) begin
          if (atSample) begin
            tickCnt <= '0;
            if (twoQ && bitCnt == 4'd0) bitCnt <= 4'd1;
            else state <= RX_XFER;
          end else tickCnt <= tickCnt + 1'b1;
        end
        RX_XFER:     state <= RX_WAITHIGH;
        RX_WAITHIGH: if (rxLine) state <= RX_IDLE;
        default:     state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  rxStrobes_t strobes,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       rxEnable,
  output logic       rtsSel,
  output logic [1:0] cfgLen,
  output logic       cfgParEn,
  output logic       cfgTwoStop,
  output logic       rxFull,
  output logic       ovrFlag,
  output logic       ferFlag,
  output logic       perFlag,
  output logic       sumFlag,
  output logic       rxIrq
);
  logic [7:0]          ctrlReg;
  logic [WORD_MAX-1:0] shiftReg, word, bufReg;
  logic [1:0]          lenQ;
  logic                parEnQ, parOddQ, parBitQ, stopBad;
  logic                topBit, parMiss, accept, clrNow, fullEff;

  assign rxEnable   = ctrlReg[0];
  assign rtsSel     = ctrlReg[1];
  assign cfgLen     = ctrlReg[4:3];
  assign cfgParEn   = ctrlReg[5];
  assign cfgTwoStop = ctrlReg[7];

  always_comb begin
    case (lenQ)
      2'd0:    begin word = {2'b00, shiftReg[8:2]}; topBit = word[6]; end
      2'd1:    begin word = {1'b0, shiftReg[8:1]};  topBit = word[7]; end
      default: begin word = shiftReg;               topBit = word[8]; end
    endcase
    parMiss = parEnQ && ((^word ^ parBitQ) != parOddQ);
    accept  = strobes.finishFrame && rxEnable && !(ctrlReg[2] && !topBit);
    clrNow  = (regRe && regAddr == 2'd2) || !rxEnable;
    fullEff = rxFull && !clrNow;
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = ctrlReg;
      2'd1:    regRdata = {3'b000, sumFlag, perFlag, ferFlag, ovrFlag, rxFull};
      2'd2:    regRdata = bufReg[7:0];
      default: regRdata = {7'b0, bufReg[8]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      shiftReg <= '0;
      bufReg   <= '0;
      lenQ     <= '0;
      parEnQ   <= 1'b0;
      parOddQ  <= 1'b0;
      parBitQ  <= 1'b0;
      stopBad  <= 1'b0;
      rxFull   <= 1'b0;
      ovrFlag  <= 1'b0;
      ferFlag  <= 1'b0;
      perFlag  <= 1'b0;
      sumFlag  <= 1'b0;
      rxIrq    <= 1'b0;
    end else begin
      if (regWe && regAddr == 2'd0) ctrlReg <= regWdata;
      if (strobes.startFrame) begin
        shiftReg <= '0;
        stopBad  <= 1'b0;
        lenQ     <= cfgLen;
        parEnQ   <= cfgParEn;
        parOddQ  <= ctrlReg[6];
      end
      if (strobes.sampleData)   shiftReg <= {rxLine, shiftReg[WORD_MAX-1:1]};
      if (strobes.sampleParity) parBitQ  <= rxLine;
      if (strobes.sampleStop)   stopBad  <= stopBad | ~rxLine;
      if (clrNow) begin
        rxFull  <= 1'b0;
        ovrFlag <= 1'b0;
        ferFlag <= 1'b0;
        perFlag <= 1'b0;
        sumFlag <= 1'b0;
      end
      rxIrq <= 1'b0;
      if (accept) begin
        bufReg  <= word;
        rxFull  <= 1'b1;
        rxIrq   <= !fullEff;
        ovrFlag <= (ovrFlag && !clrNow) || fullEff;
        ferFlag <= (ferFlag && !clrNow) || stopBad;
        perFlag <= (perFlag && !clrNow) || parMiss;
        sumFlag <= (sumFlag && !clrNow) || fullEff || stopBad || parMiss;
      end
    end
  end
endmodule

// File: rtl/uart_rx_sleep.sv
module uart_rx_sleep
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       rtsN,
  output logic       rxIrq
);
  rxStrobes_t strobes;
  logic       busy, rxEnable, rtsSel, cfgParEn, cfgTwoStop;
  logic [1:0] cfgLen;
  logic       rxFull, ovrFlag, ferFlag, perFlag, sumFlag;

  uart_rx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .rxEnable(rxEnable), .cfgLen(cfgLen), .cfgParEn(cfgParEn),
    .cfgTwoStop(cfgTwoStop), .strobes(strobes), .busy(busy)
  );

  uart_rx_dp uDp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobes(strobes),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rxEnable(rxEnable), .rtsSel(rtsSel),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgTwoStop(cfgTwoStop),
    .rxFull(rxFull), .ovrFlag(ovrFlag), .ferFlag(ferFlag),
    .perFlag(perFlag), .sumFlag(sumFlag), .rxIrq(rxIrq)
  );

  assign rtsN = !(rtsSel && rxEnable && !busy);
endmodule

// File: rtl/uart_rx_sleep_chk.sv
module uart_rx_sleep_chk (
  input logic clk,
  input logic rstN,
  input logic rtsN,
  input logic rxIrq,
  input logic rxEnable,
  input logic rxFull,
  input logic ovrFlag,
  input logic ferFlag,
  input logic perFlag,
  input logic sumFlag
);
  a_r2_rts_fall_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rtsN) |-> rxEnable);
  a_r5_irq_on_full_rise: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (rxFull && !$past(rxFull)));
  a_r5_irq_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  a_r6_overrun_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(rxFull));
  a_r9_summary_is_or: assert property (@(posedge clk) disable iff (!rstN)
    sumFlag == (ovrFlag || ferFlag || perFlag));
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxFull && !sumFlag));
endmodule

bind uart_rx_sleep uart_rx_sleep_chk uChk (
  .clk(clk), .rstN(rstN), .rtsN(rtsN), .rxIrq(rxIrq), .rxEnable(rxEnable),
  .rxFull(rxFull), .ovrFlag(ovrFlag), .ferFlag(ferFlag), .perFlag(perFlag),
  .sumFlag(sumFlag)
);

// File: tb/uart_rx_sleep_test.sv
module uart_rx_sleep_test;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16;
  logic       rxLine = 1'b1;
  logic       regWe = 1'b0, regRe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       rtsN, rxIrq;
  logic [1:0] divCnt = '0;

  int checks = 0, failures = 0, irqCount = 0, expIrq = 0;
  logic mFull = 0, mOvr = 0, mFer = 0, mPer = 0;
  logic [8:0] mBuf = '0;

  uart_rx_sleep uut (.clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rtsN(rtsN), .rxIrq(rxIrq));

  always #4 clk = ~clk;
  always @(posedge clk) divCnt <= divCnt + 2'd1;
  assign tick16 = (divCnt == 2'd3);
  always @(negedge clk) if (rstN && rxIrq) irqCount++;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrlVal(bit en, bit rts, bit slp, int n,
                                         bit parEn, bit parOdd, bit two);
    logic [1:0] len = 2'(n - 7);
    return {two, parOdd, parEn, len, slp, rts, en};
  endfunction

  function automatic logic [7:0] expStatus();
    return {3'b000, mOvr | mFer | mPer, mPer, mFer, mOvr, mFull};
  endfunction

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regRe = 1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk); regRe = 0;
    if (a == 2'd2) begin mFull = 0; mOvr = 0; mFer = 0; mPer = 0; end
  endtask

  task automatic driveBit(logic b);
    @(negedge clk); rxLine = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic sendFrame(logic [8:0] w, int n, bit parEn, bit parOdd, bit two,
                           bit badStop, bit badPar, int extraLow);
    logic p = 1'b0;
    for (int i = 0; i < n; i++) p ^= w[i];
    p = p ^ parOdd ^ badPar;
    driveBit(1'b0);
    for (int i = 0; i < n; i++) driveBit(w[i]);
    if (parEn) driveBit(p);
    driveBit(!badStop);
    if (two) driveBit(1'b1);
    repeat (extraLow) @(negedge clk);
    @(negedge clk); rxLine = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic modelXfer(logic [8:0] w, int n, bit slp, bit badStop, bit badPar);
    logic [8:0] m = 9'((1 << n) - 1);
    if (slp && !w[n-1]) return;
    if (!mFull) expIrq++;
    mOvr |= mFull; mFull = 1; mFer |= badStop; mPer |= badPar;
    mBuf = w & m;
  endtask

  task automatic checkStatus(string req);
    logic [7:0] s;
    regRead(2'd1, s);
    chk(req, s, expStatus());
    chk({req, " irq"}, irqCount, expIrq);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 rts reset", rtsN, 1); chk("R1 irq reset", rxIrq, 0);
    checkStatus("R1 status reset");
    regRead(2'd2, d); chk("R1 buf reset", d, 0);
    // R2 ready output
    regWrite(2'd0, ctrlVal(1, 1, 0, 8, 0, 0, 0));
    @(negedge clk); chk("R2 rts low when enabled", rtsN, 0);
    fork
      sendFrame(9'h0A5, 8, 0, 0, 0, 0, 0, 0);
      begin repeat (200) @(negedge clk); chk("R2 rts high in frame", rtsN, 1); end
    join
    modelXfer(9'h0A5, 8, 0, 0, 0);
    chk("R2 rts low after frame", rtsN, 0);
    checkStatus("R4 full after 8-bit frame");
    regRead(2'd3, d); chk("R10 high read", d, 0);
    checkStatus("R10 high read no clear");
    regRead(2'd2, d); chk("R4 data 8-bit", d, 8'hA5);
    checkStatus("R10 low read clears");
    // R6 overrun and R5 single irq
    sendFrame(9'h03C, 8, 0, 0, 0, 0, 0, 0); modelXfer(9'h03C, 8, 0, 0, 0);
    sendFrame(9'h05A, 8, 0, 0, 0, 0, 0, 0); modelXfer(9'h05A, 8, 0, 0, 0);
    checkStatus("R6 overrun R5 irq once");
    regRead(2'd2, d); chk("R6 newest word kept", d, 8'h5A);
    // R8 parity
    regWrite(2'd0, ctrlVal(1, 1, 0, 8, 1, 0, 0));
    sendFrame(9'h071, 8, 1, 0, 0, 0, 0, 0); modelXfer(9'h071, 8, 0, 0, 0);
    checkStatus("R8 even parity ok"); regRead(2'd2, d);
    sendFrame(9'h071, 8, 1, 0, 0, 0, 1, 0); modelXfer(9'h071, 8, 0, 0, 1);
    checkStatus("R8 even parity bad R9"); regRead(2'd2, d);
    regWrite(2'd0, ctrlVal(1, 1, 0, 9, 1, 1, 1));
    sendFrame(9'h1C3, 9, 1, 1, 1, 0, 0, 0); modelXfer(9'h1C3, 9, 0, 0, 0);
    checkStatus("R8 odd parity 9-bit");
    regRead(2'd3, d); chk("R4 9-bit high", d, 1);
    regRead(2'd2, d); chk("R4 9-bit low", d, 8'hC3);
    // R7 framing with line held low
    regWrite(2'd0, ctrlVal(1, 1, 0, 7, 0, 0, 0));
    sendFrame(9'h055, 7, 0, 0, 0, 1, 0, 300); modelXfer(9'h055, 7, 0, 1, 0);
    checkStatus("R7 framing flag");
    regRead(2'd2, d); chk("R7 word delivered", d, 8'h55);
    sendFrame(9'h02B, 7, 0, 0, 0, 0, 0, 0); modelXfer(9'h02B, 7, 0, 0, 0);
    checkStatus("R7 recovers");
    regRead(2'd2, d); chk("R7 next word", d, 8'h2B);
    // R3 start glitch
    @(negedge clk); rxLine = 0; repeat (12) @(negedge clk); rxLine = 1;
    repeat (100) @(negedge clk);
    chk("R3 glitch rts idle", rtsN, 0);
    checkStatus("R3 glitch ignored");
    // R11 sleep
    regWrite(2'd0, ctrlVal(1, 1, 1, 8, 0, 0, 0));
    sendFrame(9'h041, 8, 0, 0, 0, 0, 0, 0); modelXfer(9'h041, 8, 1, 0, 0);
    checkStatus("R11 sleep drops");
    regRead(2'd2, d); chk("R11 buffer unchanged", d, 8'h2B);
    sendFrame(9'h0C1, 8, 0, 0, 0, 0, 0, 0); modelXfer(9'h0C1, 8, 1, 0, 0);
    checkStatus("R11 address accepted");
    regRead(2'd2, d); chk("R11 address data", d, 8'hC1);
    // R12 config captured at start
    regWrite(2'd0, ctrlVal(1, 1, 0, 8, 0, 0, 0));
    fork
      sendFrame(9'h0B3, 8, 0, 0, 0, 0, 0, 0);
      begin repeat (300) @(negedge clk); regWrite(2'd0, ctrlVal(1, 1, 0, 7, 0, 0, 0)); end
    join
    modelXfer(9'h0B3, 8, 0, 0, 0);
    checkStatus("R12 status");
    regRead(2'd2, d); chk("R12 old length kept", d, 8'hB3);
    // R10 disable clears
    sendFrame(9'h011, 7, 0, 0, 0, 1, 0, 0); modelXfer(9'h011, 7, 0, 1, 0);
    regWrite(2'd0, ctrlVal(0, 1, 0, 8, 0, 0, 0));
    mFull = 0; mOvr = 0; mFer = 0; mPer = 0;
    chk("R2 rts high disabled", rtsN, 1);
    checkStatus("R10 disable clears");
    // random frames
    for (int k = 0; k < 40; k++) begin
      int n = 7 + int'($urandom % 3);
      bit parEn = 1'($urandom), parOdd = 1'($urandom), two = 1'($urandom);
      bit slp = (($urandom % 4) == 0);
      bit bs = (($urandom % 8) == 0);
      bit bp = parEn && (($urandom % 6) == 0);
      logic [8:0] w = 9'($urandom) & 9'((1 << n) - 1);
      regWrite(2'd0, ctrlVal(1, 1, slp, n, parEn, parOdd, two));
      sendFrame(w, n, parEn, parOdd, two, bs, bp, 0);
      modelXfer(w, n, slp, bs, bp);
      checkStatus("R4 random status");
      if ($urandom % 2 == 0) begin
        regRead(2'd3, d); chk("R4 random high", d, {7'b0, mBuf[8]});
        regRead(2'd2, d); chk("R4 random low", d, mBuf[7:0]);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule